// File: doc/BRIEF.md
# Quadrature Step Tracker

This block turns a pair of already-cleaned quadrature channels into a shaft position and a direction flag. On every clock it compares the channel pair it saw on the previous clock with the pair present now. A legal single-channel change is one step: one rotation sense counts the position up, the other counts it down. The position counter wraps modulo a parameterised number of positions.

An active-low origin input zeroes the position and freezes the direction flag while it is held low. Both outputs are registered and change on the same clock edge that samples the causing input. The channel, origin and reset pins are plain level signals with no handshake. The upstream logic must deliver channels that are synchronised and free of bounce. The block trusts every sampled change.

Top module: `quad_step_tracker`

## Requirements
- R1: With the channel pair written as {a,b}, the previous→current transitions 00→10, 10→11, 11→01 and 01→00 increment `position` by one and set `direction` to 1 on the clock edge that samples the new pair.
- R2: The transitions 00→01, 01→11, 11→10 and 10→00 decrement `position` by one and set `direction` to 0 on the clock edge that samples the new pair.
- R3: While `set_origin_n` is sampled low, `position` becomes 0 on that edge and `direction` keeps its value, even if a step is decoded in the same cycle.
- R4: An increment from POSITIONS-1 gives 0.
- R5: A decrement from 0 gives POSITIONS-1.
- R6: If the pair is unchanged, or both channels change in the same cycle, `position` and `direction` hold.
- R7: The previous-pair register loads {a,b} on every clock, including while the origin input is low. A step after the origin is released is therefore judged against the pair sampled on the clock just before.
- R8: While `rst_n` is low, `position` is 0, `direction` is 1 and the previous pair is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 1 | Channel A, leads for positive rotation |
| b | input | 1 | Channel B, leads for negative rotation |
| set_origin_n | input | 1 | Active-low synchronous position clear; freezes direction |
| direction | output | 1 | 1 after a positive step, 0 after a negative step |
| position | output | $clog2(POSITIONS) | Wrapping step count |

## Verification
The hardest case to reach from the ports is R7, where the channels move while the origin is held low. Only the previous-pair register sees those moves, and its effect shows only on the first cycle after release. The stimulus holds the origin low, walks the pair through one legal step, and then releases the origin together with a further step. Only a design that kept sampling during the clear decodes this as an increment. A long random phase mixes legal steps, double jumps, idle cycles and origin pulses. The random phase crosses both wrap points, and a cycle-accurate model is compared against the outputs on every clock.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef logic [1:0] ab_t; // {a,b}

  function automatic logic is_fwd(input ab_t prv, input ab_t cur);
    return (prv == 2'b00 && cur == 2'b10) || (prv == 2'b10 && cur == 2'b11) ||
           (prv == 2'b11 && cur == 2'b01) || (prv == 2'b01 && cur == 2'b00);
  endfunction

  function automatic logic is_rev(input ab_t prv, input ab_t cur);
    return (prv == 2'b00 && cur == 2'b01) || (prv == 2'b01 && cur == 2'b11) ||
           (prv == 2'b11 && cur == 2'b10) || (prv == 2'b10 && cur == 2'b00);
  endfunction
endpackage

// File: rtl/qd_step_decode.sv
module qd_step_decode
  import qd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ab_t  cur_ab,
  output logic step_up,
  output logic step_dn
);
  ab_t prev_ab;

  // previous pair follows the inputs every clock (R7), clears to 00 (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ab <= 2'b00;
    else        prev_ab <= cur_ab;
  end

  always_comb begin
    step_up = is_fwd(prev_ab, cur_ab);
    step_dn = is_rev(prev_ab, cur_ab);
  end

  // a cycle never decodes both senses (R6)
  p_one_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  // an unchanged pair never produces a step (R6)
  p_still_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_ab) == cur_ab) |-> !(step_up || step_dn));
endmodule

// File: rtl/qd_wrap_counter.sv
module qd_wrap_counter #(
  parameter int POSITIONS = 16,
  localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] count
);
  localparam logic [PW-1:0] LAST = PW'(POSITIONS - 1);

  logic [PW-1:0] nxt;

  always_comb begin
    nxt = count;
    if (!clr_n)   nxt = '0;
    else if (inc) nxt = (count == LAST) ? '0 : count + 1'b1;
    else if (dec) nxt = (count == '0) ? LAST : count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> count == '0);
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && inc && count == LAST) |=> count == '0);
  p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && dec && count == '0) |=> count == LAST);
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !inc && !dec) |=> $stable(count));
  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);
endmodule

// File: rtl/qd_dir_latch.sv
module qd_dir_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n,
  input  logic fwd,
  input  logic rev,
  output logic dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dir <= 1'b1;
    else if (hold_n && fwd) dir <= 1'b1;
    else if (hold_n && rev) dir <= 1'b0;
  end

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(dir));
  p_fwd_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && fwd) |=> dir);
  p_rev_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && rev) |=> !dir);
endmodule

// File: rtl/quad_step_tracker.sv
module quad_step_tracker #(
  parameter int POSITIONS = 16,
  localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a,
  input  logic          b,
  input  logic          set_origin_n,
  output logic          direction,
  output logic [PW-1:0] position
);
  logic up, dn;

  initial begin
    if (POSITIONS < 2) $error("quad_step_tracker: POSITIONS must be at least 2");
  end

  qd_step_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cur_ab({a, b}), .step_up(up), .step_dn(dn)
  );

  qd_wrap_counter #(.POSITIONS(POSITIONS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_n(set_origin_n), .inc(up), .dec(dn),
    .count(position)
  );

  qd_dir_latch u_dir (
    .clk(clk), .rst_n(rst_n), .hold_n(set_origin_n), .fwd(up), .rev(dn),
    .dir(direction)
  );

  // a forward step advances the position by one modulo POSITIONS (R1)
  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_origin_n && up && position != PW'(POSITIONS - 1)) |=>
      position == $past(position) + 1'b1);
  // a reverse step moves the position back by one (R2)
  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_origin_n && dn && position != '0) |=>
      position == $past(position) - 1'b1);
endmodule

// File: tb/quad_step_tracker_tb.sv
module quad_step_tracker_tb;
  localparam int POSITIONS = 16;
  localparam int PW = $clog2(POSITIONS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, set_origin_n = 1'b1;
  logic direction;
  logic [PW-1:0] position;

  always #4 clk = ~clk; // 125 MHz

  quad_step_tracker #(.POSITIONS(POSITIONS)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .set_origin_n(set_origin_n),
    .direction(direction), .position(position)
  );

  int vectors = 0;
  int errors = 0;
  int m_pos = 0;
  int m_dir = 1;
  int m_prev = 0; // {a,b}
  bit done = 0;

  // forward order of {a,b}: 00,10,11,01
  function automatic int fwd_next(int ab);
    case (ab)
      0: return 2; 2: return 3; 3: return 1; default: return 0;
    endcase
  endfunction
  function automatic int rev_next(int ab);
    case (ab)
      0: return 1; 1: return 3; 3: return 2; default: return 0;
    endcase
  endfunction

  task automatic check(string req);
    vectors++;
    if (position !== PW'(m_pos) || direction !== m_dir[0]) begin
      errors++;
      $display("FAIL %s: position=%0d direction=%0b expected position=%0d direction=%0d",
               req, position, direction, m_pos, m_dir);
    end
  endtask

  // drive one cycle, update the model, compare after the edge
  task automatic cyc(int ab, bit org, string req);
    string lbl;
    @(negedge clk);
    {a, b} = ab[1:0];
    set_origin_n = org;
    @(posedge clk);
    #1;
    lbl = req;
    if (!org) begin
      m_pos = 0;
      if (lbl == "") lbl = "R3";
    end else if (ab == fwd_next(m_prev)) begin
      if (lbl == "") lbl = (m_pos == POSITIONS - 1) ? "R4" : "R1";
      m_pos = (m_pos + 1) % POSITIONS;
      m_dir = 1;
    end else if (ab == rev_next(m_prev)) begin
      if (lbl == "") lbl = (m_pos == 0) ? "R5" : "R2";
      m_pos = (m_pos + POSITIONS - 1) % POSITIONS;
      m_dir = 0;
    end else if (lbl == "") lbl = "R6";
    m_prev = ab;
    check(lbl);
  endtask

  initial begin
    int cur;
    repeat (3) @(posedge clk);
    #1;
    check("R8"); // reset values
    @(negedge clk);
    rst_n = 1'b1;

    // forward run across the top wrap
    cur = 0;
    for (int i = 0; i < 20; i++) begin cur = fwd_next(cur); cyc(cur, 1, ""); end
    // idle
    repeat (3) cyc(cur, 1, "R6");
    // reverse run across the bottom wrap
    for (int i = 0; i < 40; i++) begin cur = rev_next(cur); cyc(cur, 1, ""); end
    // double jumps
    cyc(cur ^ 3, 1, "R6"); cur = cur ^ 3;
    cyc(cur ^ 3, 1, "R6"); cur = cur ^ 3;
    // origin with a step in the same cycle
    cur = fwd_next(cur); cyc(cur, 0, "R3");
    // move while origin low, then release with a further forward step
    cur = fwd_next(cur); cyc(cur, 0, "R7");
    cur = fwd_next(cur); cyc(cur, 1, "R7");
    cur = rev_next(cur); cyc(cur, 1, "R2");
    // decrement from 0 right after origin
    cyc(cur, 0, "R3");
    cur = rev_next(cur); cyc(cur, 1, "R5");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      int nx;
      if (r < 4) nx = fwd_next(cur);
      else if (r < 7) nx = rev_next(cur);
      else if (r < 8) nx = cur ^ 3;
      else nx = cur;
      cur = nx;
      cyc(cur, ($urandom_range(0, 19) != 0), "");
    end

    // reset in mid-run returns to reset values
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_pos = 0; m_dir = 1; m_prev = 0;
    check("R8");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule